// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a memory-mapped watchdog for a system-on-chip. Software sets a timeout through a mode register and must service the watchdog by writing a restart command to a control register. The write carries a 13-bit key next to the restart bit. If software stops servicing it, the watchdog counts down to zero and sends a one-cycle pulse on its system-reset output.

Time is counted in half-second steps. A timebase input pulses for one clock every half second. A 4-bit interval code selects a timeout from a nonlinear table that runs from half a second up to sixteen seconds. A parameter selects between two register maps. In the default map, the reset-enable bit sits in the mode register. In the alternate map, it has a configuration register of its own, and the interval code sits at a different bit position.

Software programs the interval first and then issues a keyed restart. The counter then reloads from the new interval.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, the mode register reads back as zero, the system-reset output is low, and the watchdog is disabled.
- R2: A control-register write restarts the count only when bits [13:1] hold 0x0a57 and bit 0 is 1 in the same word. The counter then reloads the full interval of the current code.
- R3: A control write with any other key, or with bit 0 clear, has no effect on the count.
- R4: The interval code gives the timeout in half-second ticks. Codes 0 to 6 give 1, 2, 4, 6, 8, 10 and 12 ticks. Codes 7 to 11 give 16, 20, 24, 28 and 32 ticks.
- R5: The reserved codes 12 to 15 behave like code 11 (32 ticks).
- R6: While the enable bit is 0, the system-reset output never goes high.
- R7: When the enable bit changes from 0 to 1, the counter reloads the full interval, with no restart command needed.
- R8: When the count runs out while both enable and reset-enable are set, the system-reset output is high for exactly one clock and the counter reloads.
- R9: With reset-enable at 0, expiry produces no pulse. The counter still reloads, so once reset-enable is set the next expiry pulses.
- R10: In the default map, control sits at 0x00 and mode at 0x04. Mode bit 0 is enable, bit 1 is reset-enable, and bits [6:3] are the code. The rest of the mode register reads 0. The control register and unmapped addresses read 0.
- R11: With the alternate map, control sits at 0x10 with the same key and restart layout. Configuration sits at 0x14 with reset-enable in bit 0. Mode sits at 0x18 with enable in bit 0 and the code in bits [7:4]. The default offsets are unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_half_s | input | 1 | One-cycle pulse every half second |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| sys_rst | output | 1 | One-cycle system-reset pulse on expiry |

## Verification
Most internal faults show up as a reset pulse on the wrong tick. A counter loaded from the wrong table entry fires too early or too late. A restart that the key check should have rejected, or one that was lost, moves the pulse by the number of ticks already counted. Each fault therefore shows within one timeout, at most 32 ticks. A faulty enable or reset-enable path shows either as a pulse that should not exist or as a pulse that never arrives. Wrong register storage shows at once on readback.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int          WDT_CODE_W    = 4;
  localparam int          WDT_KEY_W     = 13;
  localparam int          WDT_KEY_LSB   = 1;
  localparam logic [12:0] WDT_KEY       = 13'h0a57;
  localparam int          WDT_MAX_TICKS = 32;
  localparam int          WDT_CNT_W     = $clog2(WDT_MAX_TICKS + 1);

  // Half-second ticks for an interval code; reserved codes saturate.
  function automatic int wdt_ticks(input logic [WDT_CODE_W-1:0] code);
    int c;
    c = int'(code);
    if (c > 11) c = 11;
    if (c == 0)
      return 1;
    else if (c <= 6)
      return 2 * c;
    else
      return 12 + 4 * (c - 6);
  endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int ALT_LAYOUT = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  en_o,
  output logic                  rst_en_o,
  output logic [WDT_CODE_W-1:0] code_o,
  output logic                  restart_o
);

  localparam bit              USE_ALT  = (ALT_LAYOUT != 0);
  localparam logic [ADDR_W-1:0] CTRL_OFF = ADDR_W'(USE_ALT ? 'h10 : 'h00);
  localparam logic [ADDR_W-1:0] MODE_OFF = ADDR_W'(USE_ALT ? 'h18 : 'h04);
  localparam logic [ADDR_W-1:0] CFG_OFF  = ADDR_W'('h14);
  localparam int              CODE_LSB = USE_ALT ? 4 : 3;

  logic                  en_q, en_n;
  logic                  rst_en_q, rst_en_n;
  logic [WDT_CODE_W-1:0] code_q, code_n;
  logic                  restart_q, restart_n;
  logic                  key_ok;
  logic                  hit_ctrl, hit_mode, hit_cfg;
  logic                  cfg_we;
  logic                  unused_wdata;

  assign unused_wdata = ^bus_wdata;

  assign key_ok   = (bus_wdata[WDT_KEY_LSB +: WDT_KEY_W] == WDT_KEY) && bus_wdata[0];
  assign hit_ctrl = bus_wr && (bus_addr == CTRL_OFF);
  assign hit_mode = bus_wr && (bus_addr == MODE_OFF);
  assign hit_cfg  = USE_ALT && bus_wr && (bus_addr == CFG_OFF);
  assign cfg_we   = hit_mode || hit_cfg;

  // Next-state logic
  always_comb begin
    en_n      = en_q;
    rst_en_n  = rst_en_q;
    code_n    = code_q;
    restart_n = hit_ctrl && key_ok;
    if (hit_mode) begin
      en_n   = bus_wdata[0];
      code_n = bus_wdata[CODE_LSB +: WDT_CODE_W];
      if (!USE_ALT) rst_en_n = bus_wdata[1];
    end
    if (hit_cfg) rst_en_n = bus_wdata[0];
  end

  // State registers with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      rst_en_q <= 1'b0;
      code_q   <= '0;
    end else if (cfg_we) begin
      en_q     <= en_n;
      rst_en_q <= rst_en_n;
      code_q   <= code_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) restart_q <= 1'b0;
    else        restart_q <= restart_n;
  end

  // Read mux, one variant per layout
  generate
    if (USE_ALT) begin : g_rd_alt
      always_comb begin
        bus_rdata = '0;
        if (bus_addr == MODE_OFF) begin
          bus_rdata[0]                     = en_q;
          bus_rdata[CODE_LSB +: WDT_CODE_W] = code_q;
        end else if (bus_addr == CFG_OFF) begin
          bus_rdata[0] = rst_en_q;
        end
      end
    end else begin : g_rd_dflt
      always_comb begin
        bus_rdata = '0;
        if (bus_addr == MODE_OFF) begin
          bus_rdata[0]                     = en_q;
          bus_rdata[1]                     = rst_en_q;
          bus_rdata[CODE_LSB +: WDT_CODE_W] = code_q;
        end
      end
    end
  endgenerate

  assign en_o      = en_q;
  assign rst_en_o  = rst_en_q;
  assign code_o    = code_q;
  assign restart_o = restart_q;

  AST_BAD_KEY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CTRL_OFF &&
     (bus_wdata[13:1] != 13'h0a57 || !bus_wdata[0])) |=> !restart_o); // R3

  AST_CTRL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == CTRL_OFF) |-> (bus_rdata == '0)); // R10

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  en,
  input  logic                  rst_en,
  input  logic [WDT_CODE_W-1:0] code,
  input  logic                  restart,
  output logic                  sys_rst
);

  logic [WDT_CNT_W-1:0] cnt_q, cnt_n, reload_val;
  logic                 en_d_q;
  logic                 sys_rst_q, sys_rst_n;
  logic                 reload, expire, cnt_we;

  assign reload_val = WDT_CNT_W'(wdt_ticks(code));
  assign reload     = en && (restart || !en_d_q);
  assign expire     = en && !reload && tick && (cnt_q <= WDT_CNT_W'(1));
  assign cnt_we     = reload || (en && tick);

  // Next-state logic
  always_comb begin
    cnt_n     = cnt_q;
    sys_rst_n = 1'b0;
    if (reload) begin
      cnt_n = reload_val;
    end else if (en && tick) begin
      if (expire) begin
        cnt_n     = reload_val;
        sys_rst_n = rst_en;
      end else begin
        cnt_n = cnt_q - WDT_CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d_q    <= 1'b0;
      sys_rst_q <= 1'b0;
    end else begin
      en_d_q    <= en;
      sys_rst_q <= sys_rst_n;
    end
  end

  assign sys_rst = sys_rst_q;

  AST_NO_RST_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sys_rst); // R6

  AST_NO_RST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_en |=> !sys_rst); // R9

  AST_CNT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    (en && en_d_q) |-> (cnt_q != '0)); // R7

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= WDT_CNT_W'(WDT_MAX_TICKS)); // R5

  AST_RST_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> $past(tick)); // R8

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int ALT_LAYOUT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_half_s,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sys_rst
);

  logic                  rst_meta_q, rst_sync_q;
  logic                  en, rst_en, restart;
  logic [WDT_CODE_W-1:0] code;

  // Reset asserts at once and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  wdt_regs #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .ALT_LAYOUT(ALT_LAYOUT)
  ) regs_i (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .en_o     (en),
    .rst_en_o (rst_en),
    .code_o   (code),
    .restart_o(restart)
  );

  wdt_counter cnt_i (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .tick   (tick_half_s),
    .en     (en),
    .rst_en (rst_en),
    .code   (code),
    .restart(restart),
    .sys_rst(sys_rst)
  );

endmodule

// File: tb/keyed_wdt_tb_top.sv
module keyed_wdt_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [31:0] RESTART_WORD = (32'h0a57 << 1) | 32'h1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick_half_s = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] rdata_d, rdata_a;
  logic              srst_d, srst_a;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_wdt #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ALT_LAYOUT(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_half_s(tick_half_s), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_d), .sys_rst(srst_d));

  keyed_wdt #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ALT_LAYOUT(1)) dut_alt_i (
    .clk(clk), .rst_n(rst_n), .tick_half_s(tick_half_s), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .sys_rst(srst_a));

  function automatic int exp_ticks(input int code);
    int c;
    c = (code > 11) ? 11 : code;
    if (c == 0) return 1;
    if (c <= 6) return 2 * c;
    return 12 + 4 * (c - 6);
  endfunction

  function automatic logic [31:0] mode_word(input bit en, input bit ren, input int code);
    return {25'd0, 4'(code), 1'b0, ren, en};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input bit alt, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = alt ? rdata_a : rdata_d;
  endtask

  // One timebase pulse; reports whether the selected DUT fired; checks pulse width
  task automatic tick(input bit alt, output bit hit);
    @(negedge clk);
    tick_half_s = 1'b1;
    @(negedge clk);
    tick_half_s = 1'b0;
    hit = alt ? srst_a : srst_d;
    @(negedge clk);
    if (hit) chk(!(alt ? srst_a : srst_d), "R8 pulse width", 1, 0);
    @(negedge clk);
  endtask

  task automatic count_to_pulse(input bit alt, input int maxn, output int n);
    bit h;
    n = 0;
    for (int i = 1; i <= maxn; i++) begin
      tick(alt, h);
      if (h) begin n = i; return; end
    end
  endtask

  task automatic ticks_no_pulse(input bit alt, input int k, output int hits);
    bit h;
    hits = 0;
    for (int i = 0; i < k; i++) begin
      tick(alt, h);
      if (h) hits++;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        done = 1;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    int n, h;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(0, 8'h04, d); chk(d == 0, "R1 mode after reset", d, 0);
    chk(srst_d == 0, "R1 sys_rst after reset", srst_d, 0);
    ticks_no_pulse(0, 3, h); chk(h == 0, "R1 idle after reset", h, 0);

    // R10 readback and zero-reading fields
    wr(8'h04, 32'hFFFF_FFFF);
    rd(0, 8'h04, d); chk(d == 32'h7B, "R10 mode readback", d, 32'h7B);
    wr(8'h00, RESTART_WORD);
    rd(0, 8'h00, d); chk(d == 0, "R10 control reads zero", d, 0);
    rd(0, 8'h08, d); chk(d == 0, "R10 unmapped reads zero", d, 0);
    wr(8'h04, 32'h0);

    // R4/R5 full interval table
    for (int c = 0; c < 16; c++) begin
      wr(8'h04, mode_word(1, 1, c));
      wr(8'h00, RESTART_WORD);
      count_to_pulse(0, 40, n);
      chk(n == exp_ticks(c), (c > 11) ? "R5 reserved code" : "R4 interval table", n, exp_ticks(c));
    end

    // R8 periodic reload after expiry
    wr(8'h04, mode_word(1, 1, 2));
    wr(8'h00, RESTART_WORD);
    count_to_pulse(0, 40, n); chk(n == 4, "R8 first expiry", n, 4);
    count_to_pulse(0, 40, n); chk(n == 4, "R8 reload after expiry", n, 4);

    // R2 valid restart mid-count
    wr(8'h00, RESTART_WORD);
    ticks_no_pulse(0, 3, h);
    wr(8'h00, RESTART_WORD);
    count_to_pulse(0, 40, n); chk(n == 4 && h == 0, "R2 keyed restart reloads", n, 4);

    // R3 bad key and missing restart bit ignored
    wr(8'h00, RESTART_WORD);
    ticks_no_pulse(0, 2, h);
    wr(8'h00, (32'h0a56 << 1) | 32'h1);
    wr(8'h00, RESTART_WORD & ~32'h1);
    count_to_pulse(0, 40, n); chk(n == 2, "R3 bad control writes ignored", n, 2);

    // R6 disabled never pulses
    wr(8'h04, mode_word(0, 1, 0));
    ticks_no_pulse(0, 6, h); chk(h == 0, "R6 no pulse while disabled", h, 0);
    wr(8'h00, RESTART_WORD);
    ticks_no_pulse(0, 3, h); chk(h == 0, "R6 restart while disabled", h, 0);

    // R7 enable rising edge reloads
    wr(8'h04, mode_word(1, 1, 2));
    wr(8'h00, RESTART_WORD);
    ticks_no_pulse(0, 3, h);
    wr(8'h04, mode_word(0, 1, 2));
    wr(8'h04, mode_word(1, 1, 2));
    count_to_pulse(0, 40, n); chk(n == 4 && h == 0, "R7 enable reloads", n, 4);

    // R9 reset-enable masks pulse, counter still reloads
    wr(8'h04, mode_word(1, 0, 0));
    wr(8'h00, RESTART_WORD);
    ticks_no_pulse(0, 5, h); chk(h == 0, "R9 masked expiry", h, 0);
    wr(8'h04, mode_word(1, 1, 0));
    count_to_pulse(0, 5, n); chk(n == 1, "R9 pulse after unmask", n, 1);

    // Random: code, partial count, bad-key writes, then the remaining ticks
    for (int it = 0; it < 12; it++) begin
      int c, t, k, nb;
      c = int'($urandom % 16);
      t = exp_ticks(c);
      k = int'($urandom % t);
      nb = int'($urandom % 3) + 1;
      wr(8'h04, mode_word(1, 1, c));
      wr(8'h00, RESTART_WORD);
      ticks_no_pulse(0, k, h);
      chk(h == 0, "R4 random no early pulse", h, 0);
      for (int b = 0; b < nb; b++) begin
        logic [12:0] key;
        key = 13'($urandom);
        if (key == 13'h0a57) key = key ^ 13'h1;
        wr(8'h00, {18'd0, key, 1'b1});
      end
      count_to_pulse(0, 40, n);
      chk(n == t - k, "R3 random bad keys keep count", n, t - k);
    end

    // R11 alternate layout
    wr(8'h04, 32'h0);
    rd(1, 8'h04, d); chk(d == 0, "R11 alt default offset unmapped", d, 0);
    wr(8'h18, 32'h11);
    wr(8'h14, 32'h1);
    rd(1, 8'h18, d); chk(d == 32'h11, "R11 alt mode readback", d, 32'h11);
    rd(1, 8'h14, d); chk(d == 32'h1, "R11 alt config readback", d, 1);
    rd(1, 8'h10, d); chk(d == 0, "R11 alt control reads zero", d, 0);
    wr(8'h10, RESTART_WORD);
    count_to_pulse(1, 40, n); chk(n == 2, "R11 alt interval", n, 2);
    wr(8'h14, 32'h0);
    ticks_no_pulse(1, 4, h); chk(h == 0, "R11 alt config masks reset", h, 0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule